// File: doc/BRIEF.md
# Bus Timeout Watchdog with Non-Maskable Interrupt

This block guards a processor bus on which every cycle waits until some target answers. Only a decoded memory or I/O device that recognises its address returns ready. A cycle aimed at an empty address would otherwise hang the processor for good. A retriggerable down-timer watches for that case. The address-latch strobe at the start of each bus cycle restarts the timer. A periodic refresh or DMA-completion strobe restarts it too, so that long internal processor work with no bus traffic does not look like a stall.

Only cycles that fall in the region served by external acknowledging devices are watched. If such a cycle goes unanswered for the programmed number of clocks, the block does two things. It drives ready for one clock, which ends the stalled cycle, and it raises a fixed-width non-maskable interrupt pulse. A front-panel reset button drives the same interrupt line. The button is synchronised and debounced first. Its filtered level can be read at a status port, so the interrupt handler can tell a button press from a bus timeout.

Top module: `bus_timeout_nmi`

## Requirements
- R1: `ready_o` is high in every cycle in which `dev_ready_i` is high, whatever the timer state.
- R2: A bus-cycle strobe with `ext_region_i` high arms the timer. If no restart follows, `ready_o` pulses high for exactly one clock, TIMEOUT_CYC clocks after the clock edge that sampled the strobe.
- R3: While the timer is armed, each refresh strobe restarts the full TIMEOUT_CYC count.
- R4: A new bus-cycle strobe restarts the count. No forced ready occurs in the clock that follows it.
- R5: A bus-cycle strobe with `ext_region_i` low disarms the timer. No timeout follows, however long the cycle stalls.
- R6: A device ready while the timer is armed completes the cycle and disarms the timer, so no timeout follows.
- R7: Every NMI pulse lasts NMI_WIDTH clocks. The pulse caused by a timeout starts in the same clock as the forced ready.
- R8: After a timeout, the timer stays disarmed and raises no second forced ready or NMI until a new bus-cycle strobe.
- R9: The panel button input is passed through a two-stage synchroniser. The filtered level changes only after the synchronised input has differed from it for DEBOUNCE_CYC consecutive clocks. Shorter glitches change neither the status bit nor the NMI.
- R10: A filtered button press (a low-to-high change of the filtered level) raises an NMI pulse. A release raises none.
- R11: When `io_addr_i` equals STATUS_ADDR (default 8'h60), `rd_data_o` bit 1 carries the filtered button level and every other bit is 0. At any other address `rd_data_o` is 0.
- R12: After reset, `nmi_o` is low, the timer is disarmed and the filtered button level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cycle_start_i | input | 1 | Address-latch strobe, one clock per bus cycle |
| ext_region_i | input | 1 | Current cycle targets the externally acknowledged region |
| refresh_i | input | 1 | Refresh / DMA-completion restart strobe |
| dev_ready_i | input | 1 | Ready from a decoded valid target |
| panel_sw_i | input | 1 | Raw front-panel reset button, high when pressed |
| io_addr_i | input | ADDR_W | I/O read address for the status port |
| ready_o | output | 1 | Ready to the bus master (device or forced) |
| nmi_o | output | 1 | Non-maskable interrupt request |
| rd_data_o | output | 8 | Status port read data |

## Verification
The bench builds the block with TIMEOUT_CYC=40, DEBOUNCE_CYC=8 and NMI_WIDTH=4, in place of a timeout of thousands of clocks. At these values a full expiry, a stall kept alive by refresh strobes spaced 25 clocks apart, and a restart by a second strobe all fit in short windows. The exact clock of each forced ready can then be predicted and compared. The small debounce count lets a 3-clock glitch be shown to be rejected, while a held press shows up in the status bit within a few dozen clocks.

// File: rtl/bto_pkg.sv
package bto_pkg;

    // bit of the status byte that reflects the filtered panel button
    localparam int STATUS_SW_BIT = 1;

    // counter width for a terminal count of n (at least one bit)
    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/bto_timer.sv
module bto_timer
    import bto_pkg::*;
#(
    parameter int TIMEOUT_CYC = 5000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cycle_start_i,
    input  logic ext_region_i,
    input  logic refresh_i,
    input  logic dev_ready_i,
    output logic fire_o,
    output logic armed_o
);
    localparam int CW = cnt_width(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
        logic          fire;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (cycle_start_i) begin
            st_d.armed = ext_region_i;
            st_d.cnt   = '0;
        end else if (st_q.armed) begin
            if (dev_ready_i) begin
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
            end else if (refresh_i) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == LAST) begin
                st_d.armed = 1'b0;
                st_d.fire  = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign fire_o  = st_q.fire;
    assign armed_o = st_q.armed;
endmodule

// File: rtl/bto_debounce.sv
module bto_debounce
    import bto_pkg::*;
#(
    parameter int DEBOUNCE_CYC = 100000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic level_o,
    output logic rise_o
);
    localparam int CW = cnt_width(DEBOUNCE_CYC);
    localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYC - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          lvl;
        logic          rise;
        logic [CW-1:0] cnt;
    } deb_t;

    deb_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = raw_i;
        st_d.s2   = st_q.s1;
        st_d.rise = 1'b0;
        if (st_q.s2 != st_q.lvl) begin
            if (st_q.cnt == LAST) begin
                st_d.lvl  = st_q.s2;
                st_d.rise = st_q.s2;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign level_o = st_q.lvl;
    assign rise_o  = st_q.rise;
endmodule

// File: rtl/bto_nmi_pulse.sv
module bto_nmi_pulse
    import bto_pkg::*;
#(
    parameter int NMI_WIDTH = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic nmi_o
);
    localparam int CW = cnt_width(NMI_WIDTH + 1);
    localparam logic [CW-1:0] RELOAD = CW'(NMI_WIDTH - 1);

    typedef struct packed {
        logic [CW-1:0] left;
    } pls_t;

    pls_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig_i)                st_d.left = RELOAD;
        else if (st_q.left != '0)  st_d.left = st_q.left - 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // the trigger cycle is the first clock of the pulse
    assign nmi_o = trig_i | (st_q.left != '0);
endmodule

// File: rtl/bus_timeout_nmi.sv
module bus_timeout_nmi
    import bto_pkg::*;
#(
    parameter int          TIMEOUT_CYC  = 5000,
    parameter int          DEBOUNCE_CYC = 100000,
    parameter int          NMI_WIDTH    = 16,
    parameter int          ADDR_W       = 8,
    parameter logic [7:0]  STATUS_ADDR  = 8'h60
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cycle_start_i,
    input  logic              ext_region_i,
    input  logic              refresh_i,
    input  logic              dev_ready_i,
    input  logic              panel_sw_i,
    input  logic [ADDR_W-1:0] io_addr_i,
    output logic              ready_o,
    output logic              nmi_o,
    output logic [7:0]        rd_data_o
);
    logic tmo_fire, tmo_armed, sw_level, sw_rise, stat_sel;

    bto_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk_i, .rst_ni,
        .cycle_start_i, .ext_region_i, .refresh_i, .dev_ready_i,
        .fire_o (tmo_fire),
        .armed_o(tmo_armed)
    );

    bto_debounce #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_deb (
        .clk_i, .rst_ni,
        .raw_i  (panel_sw_i),
        .level_o(sw_level),
        .rise_o (sw_rise)
    );

    bto_nmi_pulse #(.NMI_WIDTH(NMI_WIDTH)) u_nmi (
        .clk_i, .rst_ni,
        .trig_i(tmo_fire | sw_rise),
        .nmi_o
    );

    assign ready_o  = dev_ready_i | tmo_fire;
    assign stat_sel = (io_addr_i == ADDR_W'(STATUS_ADDR));

    always_comb begin
        rd_data_o = '0;
        if (stat_sel) rd_data_o[STATUS_SW_BIT] = sw_level;
    end
endmodule

// File: rtl/bto_checker.sv
module bto_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       cycle_start_i,
    input logic       ext_region_i,
    input logic       dev_ready_i,
    input logic       ready_o,
    input logic       nmi_o,
    input logic [7:0] rd_data_o,
    input logic       tmo_fire,
    input logic       tmo_armed,
    input logic       sw_level,
    input logic       sw_rise,
    input logic       stat_sel
);
    assert_dev_ready_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dev_ready_i |-> ready_o);

    assert_forced_ready_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmo_fire |=> !tmo_fire);

    assert_restart_no_fire_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cycle_start_i |=> !tmo_fire);

    assert_outside_region_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cycle_start_i && !ext_region_i) |=> !tmo_armed);

    assert_nmi_with_timeout_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmo_fire |-> (nmi_o && ready_o));

    assert_disarm_after_fire_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmo_fire |-> !tmo_armed);

    assert_press_nmi_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_rise |-> nmi_o);

    assert_status_bit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_sel |-> (rd_data_o == {6'b0, sw_level, 1'b0}));

    assert_status_other_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stat_sel |-> (rd_data_o == 8'h00));
endmodule

bind bus_timeout_nmi bto_checker chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cycle_start_i(cycle_start_i),
    .ext_region_i (ext_region_i),
    .dev_ready_i  (dev_ready_i),
    .ready_o      (ready_o),
    .nmi_o        (nmi_o),
    .rd_data_o    (rd_data_o),
    .tmo_fire     (tmo_fire),
    .tmo_armed    (tmo_armed),
    .sw_level     (sw_level),
    .sw_rise      (sw_rise),
    .stat_sel     (stat_sel)
);

// File: tb/bus_timeout_nmi_tb_top.sv
module bus_timeout_nmi_tb_top;
    localparam int T  = 40;
    localparam int DB = 8;
    localparam int NW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_st = 1'b0, ext_reg = 1'b0, refr = 1'b0, dev_rdy = 1'b0, sw = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       ready, nmi;
    logic [7:0] rdata;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int nmi_rises = 0;
    int nmi_run = 0;
    int         exp_cyc[$];
    string      exp_tag[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bus_timeout_nmi #(.TIMEOUT_CYC(T), .DEBOUNCE_CYC(DB), .NMI_WIDTH(NW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .cycle_start_i(cyc_st), .ext_region_i(ext_reg), .refresh_i(refr),
        .dev_ready_i(dev_rdy), .panel_sw_i(sw), .io_addr_i(addr),
        .ready_o(ready), .nmi_o(nmi), .rd_data_o(rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one-clock strobe; returns the cyc value while it was driven
    task automatic strobe_cycle(input bit ext, output int at);
        at = cyc;
        cyc_st = 1'b1; ext_reg = ext;
        tick(1);
        cyc_st = 1'b0;
    endtask

    task automatic strobe_refresh(output int at);
        at = cyc;
        refr = 1'b1;
        tick(1);
        refr = 1'b0;
    endtask

    task automatic expect_fire(input int drive_cyc, input string tag);
        exp_cyc.push_back(drive_cyc + 1 + T);
        exp_tag.push_back(tag);
    endtask

    // monitor: samples just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (ready && !dev_rdy) begin
                    if (exp_cyc.size() == 0) begin
                        chk(1'b0, "R8 unexpected forced ready", cyc, -1);
                    end else begin
                        int e;
                        string t;
                        e = exp_cyc.pop_front();
                        t = exp_tag.pop_front();
                        chk(cyc == e, t, cyc, e);
                        chk(nmi == 1'b1, "R7 nmi with forced ready", int'(nmi), 1);
                    end
                end
                if (nmi) begin
                    if (nmi_run == 0) nmi_rises++;
                    nmi_run++;
                end else if (nmi_run != 0) begin
                    chk(nmi_run == NW, "R7 nmi width", nmi_run, NW);
                    nmi_run = 0;
                end
            end
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        summary();
    end

    initial begin
        int a, b, n0;
        tick(3);
        #1;
        chk(nmi == 1'b0, "R12 nmi in reset", int'(nmi), 0);
        chk(ready == 1'b0, "R12 ready in reset", int'(ready), 0);
        rst_n = 1'b1;
        addr = 8'h60;
        tick(2);
        #1;
        chk(rdata == 8'h00, "R12 status after reset", rdata, 0);

        // R1 passthrough
        dev_rdy = 1'b1; #1;
        chk(ready == 1'b1, "R1 device ready passes", int'(ready), 1);
        tick(1); dev_rdy = 1'b0; tick(2);

        // R2 plain expiry, then R8 no refire
        n0 = nmi_rises;
        strobe_cycle(1'b1, a);
        expect_fire(a, "R2 timeout clock");
        tick(T + 80);
        chk(exp_cyc.size() == 0, "R2 timeout observed", exp_cyc.size(), 0);
        chk(nmi_rises == n0 + 1, "R8 single nmi per timeout", nmi_rises - n0, 1);

        // R3 refresh restarts
        strobe_cycle(1'b1, a);
        tick(24);
        strobe_refresh(b);
        tick(24);
        strobe_refresh(b);
        expect_fire(b, "R3 refresh restarts count");
        tick(T + 20);
        chk(exp_cyc.size() == 0, "R3 timeout after last refresh", exp_cyc.size(), 0);

        // R4 new strobe restarts
        strobe_cycle(1'b1, a);
        tick(29);
        strobe_cycle(1'b1, b);
        expect_fire(b, "R4 second strobe restarts count");
        tick(T + 20);
        chk(exp_cyc.size() == 0, "R4 timeout from second strobe", exp_cyc.size(), 0);

        // R5 outside region
        n0 = nmi_rises;
        strobe_cycle(1'b0, a);
        tick(3 * T);
        chk(nmi_rises == n0, "R5 no timeout outside region", nmi_rises - n0, 0);

        // R6 device ready disarms
        strobe_cycle(1'b1, a);
        tick(10);
        dev_rdy = 1'b1;
        tick(1);
        dev_rdy = 1'b0;
        tick(2 * T);
        chk(nmi_rises == n0, "R6 no timeout after device ready", nmi_rises - n0, 0);

        // R9 glitch rejected
        sw = 1'b1; tick(3); sw = 1'b0;
        tick(20); #1;
        chk(rdata == 8'h00, "R9 glitch not in status", rdata, 0);
        chk(nmi_rises == n0, "R9 glitch raises no nmi", nmi_rises - n0, 0);

        // R10/R11 held press
        sw = 1'b1;
        tick(DB + 8); #1;
        chk(rdata == 8'h02, "R11 status bit1 at 0x60", rdata, 2);
        chk(nmi_rises == n0 + 1, "R10 press raises nmi", nmi_rises - n0, 1);
        addr = 8'h61; #1;
        chk(rdata == 8'h00, "R11 other address reads 0", rdata, 0);
        addr = 8'h60;

        // R10 release raises none
        sw = 1'b0;
        tick(DB + 8); #1;
        chk(rdata == 8'h00, "R11 status cleared on release", rdata, 0);
        chk(nmi_rises == n0 + 1, "R10 release raises no nmi", nmi_rises - n0, 1);

        tick(5);
        summary();
    end
endmodule